// File: doc/BRIEF.md
# Multi-Mode Capture and Event Timer

This block is a down-counting timer with a software-loaded reload value and four operating modes. In free-running timer mode it divides a count clock enable. In event mode it counts edges on an external input pin. In period mode it captures the running count at a selected pin edge. In high/low pulse-width mode it captures at both pin edges. The pin is brought into the clock domain through a synchroniser and an edge detector. Every count and capture decision is made on the detected edges.

Software drives the block through a simple strobed register port with three word addresses. Address 0 is the mode register. Address 1 is the count port: a write loads the count, and a read returns the count or the capture. Address 2 holds the interrupt request flags. In the two measurement modes, an accepted edge latches the count into a capture register and then reloads the counter. The captured value is frozen until software reads address 1 once. Two sticky flags go to an interrupt controller outside the block: an underflow request and a pin-edge request.

Top module: `capture_event_timer`

## Requirements
- R1: After reset the mode register reads 0x0000, both request flags read 0, and `irq_unf`/`irq_pin` are low.
- R2: In timer mode (mode field 00), each cycle with `cnt_en` high decrements the counter. A tick at zero reloads the counter instead of decrementing. A write to address 1 sets both the reload value and the counter. So after N ticks from reload R, the count is R − (N mod (R+1)).
- R3: While the stop bit (mode register bit 7) is 1, the counter does not change on ticks or on pin edges.
- R4: In event mode (mode field 10), the counter steps on pin edges instead of `cnt_en`. It steps on rising edges when the edge bit (mode register bit 6) is 0, and on falling edges when it is 1. `cnt_en` has no effect in this mode.
- R5: In modes 00, 01 and 10, the pin request flag is set on a falling edge when the edge bit is 0, and on a rising edge when it is 1.
- R6: In period mode (mode field 01), the accepted edge is falling when the edge bit is 0 and rising when it is 1. On that edge the count is captured and the counter reloads. In both measurement modes, a read of address 1 returns the capture.
- R7: A capture stays frozen from the edge that takes it until the first read of address 1. Later accepted edges still reload the counter but leave the capture unchanged. The first accepted edge after that read captures again.
- R8: In pulse-width mode (mode field 11), both pin edges capture, reload the counter and set the pin request flag, whatever the edge bit holds.
- R9: A tick at count zero sets the underflow flag. Address 2 reads the underflow flag in bit 0 and the pin flag in bit 1. Writing 1 to either bit clears that flag.
- R10: The mode register keeps bits 7:4 (stop, edge, mode[1:0]). Bits 3:0 and all bits above 7 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count clock enable (one tick per cycle while high) |
| pin_in | input | 1 | Asynchronous external input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (releases a held capture) |
| addr | input | 2 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq_unf | output | 1 | Sticky underflow request |
| irq_pin | output | 1 | Sticky pin-edge request |

## Verification
The hardest state to reach from the ports is a capture that is still held while a second accepted edge arrives. This must reload the counter without overwriting the capture. The stimulus reaches it by taking a capture, ticking a known number of times, and then producing another full pin cycle without reading address 1. The read that follows must return the first value. After that read, a third edge must capture the count that followed the silent reload. The bench also drives pin edges of the "wrong" polarity before the right one, in each edge mode. This separates a pin request or capture on the selected edge from one on any edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_EVENT  = 2'b10,
    MODE_PWHL   = 2'b11
  } tmode_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;
endpackage

// File: rtl/ctr_pin_sync.sv
module ctr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = pin_in;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], pin_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    rise = sync_q[STAGES-1] & ~prev_q;
    fall = ~sync_q[STAGES-1] & prev_q;
  end

  // R4 detected edges last a single cycle
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         tick,
  input  logic         edge_acc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rd_clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic         unf_pulse
);
  logic [W-1:0] cnt_q, cnt_d, rel_q, rel_d, cap_q, cap_d;
  logic         held_q, held_d;

  always_comb begin
    cnt_d     = cnt_q;
    rel_d     = rel_q;
    cap_d     = cap_q;
    held_d    = rd_clr ? 1'b0 : held_q;
    unf_pulse = 1'b0;
    if (load) begin
      rel_d = load_val;
      cnt_d = load_val;
    end else if (!stop) begin
      if (edge_acc) begin
        if (!held_q) begin
          cap_d  = cnt_q;
          held_d = 1'b1;
        end
        cnt_d = rel_q;
      end else if (tick) begin
        if (cnt_q == '0) begin
          cnt_d     = rel_q;
          unf_pulse = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      cap_q  <= '0;
      held_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      cap_q  <= cap_d;
      held_q <= held_d;
    end
  end

  assign cnt = cnt_q;
  assign cap = cap_q;

  // R3
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable(cnt_q));
  // R7
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rd_clr) |=> $stable(cap_q));
endmodule

// File: rtl/capture_event_timer.sv
module capture_event_timer #(
  parameter int W         = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pin_in,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq_unf,
  output logic         irq_pin
);
  import ctr_pkg::*;

  localparam int MBITS = 4;

  logic [MBITS-1:0] mode_q, mode_d;
  logic             unf_q, unf_d, pin_q, pin_d;
  logic             rise, fall, stop, esel, measure;
  logic             tick, edge_acc, pin_evt, rd_clr, load;
  logic [W-1:0]     cnt, cap;
  logic             unf_pulse;
  tmode_e           mode;

  assign stop    = mode_q[3];
  assign esel    = mode_q[2];
  assign mode    = tmode_e'(mode_q[1:0]);
  assign measure = (mode == MODE_PERIOD) || (mode == MODE_PWHL);

  ctr_pin_sync #(.STAGES(SYNC_STGS)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  always_comb begin
    tick     = 1'b0;
    edge_acc = 1'b0;
    pin_evt  = esel ? rise : fall;
    unique case (mode)
      MODE_TIMER:  tick = cnt_en;
      MODE_EVENT:  tick = esel ? fall : rise;
      MODE_PERIOD: begin
        tick     = cnt_en;
        edge_acc = esel ? rise : fall;
      end
      MODE_PWHL: begin
        tick     = cnt_en;
        edge_acc = rise | fall;
        pin_evt  = rise | fall;
      end
      default: ;
    endcase
  end

  assign load   = wr_en && (addr == ADDR_COUNT);
  assign rd_clr = rd_en && (addr == ADDR_COUNT) && measure;

  ctr_count_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .stop(stop), .tick(tick), .edge_acc(edge_acc),
    .load(load), .load_val(wdata), .rd_clr(rd_clr),
    .cnt(cnt), .cap(cap), .unf_pulse(unf_pulse)
  );

  always_comb begin
    mode_d = mode_q;
    unf_d  = unf_q;
    pin_d  = pin_q;
    if (wr_en && (addr == ADDR_MODE)) mode_d = wdata[7:4];
    if (wr_en && (addr == ADDR_FLAGS)) begin
      if (wdata[0]) unf_d = 1'b0;
      if (wdata[1]) pin_d = 1'b0;
    end
    if (unf_pulse) unf_d = 1'b1;
    if (pin_evt)   pin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      unf_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      unf_q  <= unf_d;
      pin_q  <= pin_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_MODE:  rdata[7:4] = mode_q;
      ADDR_COUNT: rdata      = measure ? cap : cnt;
      ADDR_FLAGS: rdata[1:0] = {pin_q, unf_q};
      default:    rdata      = '0;
    endcase
  end

  assign irq_unf = unf_q;
  assign irq_pin = pin_q;

  // R9
  unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !load && !edge_acc && cnt == '0) |=> irq_unf);
  // R5
  pin_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PWHL && (esel ? rise : fall)) |=> irq_pin);
  // R8
  pwhl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWHL && (rise || fall)) |=> irq_pin);
endmodule

// File: tb/capture_event_timer_tb_top.sv
module capture_event_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, cnt_en, pin_in, wr_en, rd_en;
  logic [1:0]   addr;
  logic [W-1:0] wdata, rdata;
  logic         irq_unf, irq_pin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  capture_event_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_in(pin_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_unf(irq_unf), .irq_pin(irq_pin)
  );

  localparam int NV = 5;
  localparam int VREL [NV] = '{5, 3, 0, 10, 255};
  localparam int VTCK [NV] = '{3, 4, 1, 25, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    addr = a; wdata = W'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      @(negedge clk);
      cnt_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic pin(input logic v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic int mw(input int stp, input int sel, input int md);
    return (stp << 7) | (sel << 6) | (md << 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; cnt_en = 1'b0; pin_in = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 mode", v, 0);
    rd(2'd2, v); chk("R1 flags", v, 0);
    chk("R1 irq_unf", int'(irq_unf), 0);
    chk("R1 irq_pin", int'(irq_pin), 0);

    // R2 / R9 vector table, timer mode
    wr(2'd0, mw(0, 0, 0));
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 3);
      wr(2'd1, VREL[i]);
      tick(VTCK[i]);
      rd(2'd1, v);
      chk("R2 count", v, VREL[i] - (VTCK[i] % (VREL[i] + 1)));
      chk("R9 unf", int'(irq_unf), (VTCK[i] > VREL[i]) ? 1 : 0);
    end

    // R9 flag clear by write-one
    wr(2'd1, 0); tick(1);
    rd(2'd2, v); chk("R9 flag set", v & 1, 1);
    wr(2'd2, 1);
    rd(2'd2, v); chk("R9 flag cleared", v & 1, 0);

    // R3 stop bit
    wr(2'd1, 30); tick(2);
    wr(2'd0, mw(1, 0, 0)); tick(5);
    rd(2'd1, v); chk("R3 stopped", v, 28);
    wr(2'd0, mw(0, 0, 0)); tick(1);
    rd(2'd1, v); chk("R3 restarted", v, 27);

    // R4 / R5 event mode, edge bit 0
    wr(2'd0, mw(0, 0, 2)); wr(2'd1, 20); wr(2'd2, 3);
    pin(1'b1);
    rd(2'd1, v); chk("R4 rise counts", v, 19);
    chk("R5 no irq on rise sel0", int'(irq_pin), 0);
    pin(1'b0);
    rd(2'd1, v); chk("R4 fall ignored", v, 19);
    chk("R5 irq on fall sel0", int'(irq_pin), 1);
    tick(3);
    rd(2'd1, v); chk("R4 cnt_en ignored", v, 19);

    // R4 / R5 event mode, edge bit 1
    wr(2'd0, mw(0, 1, 2)); wr(2'd2, 3);
    pin(1'b1);
    rd(2'd1, v); chk("R4 rise ignored sel1", v, 19);
    chk("R5 irq on rise sel1", int'(irq_pin), 1);
    pin(1'b0);
    rd(2'd1, v); chk("R4 fall counts sel1", v, 18);

    // R6 / R7 period mode, edge bit 0
    wr(2'd0, mw(0, 0, 1)); wr(2'd1, 100); wr(2'd2, 3);
    tick(10);
    pin(1'b1);
    chk("R5 no irq on rise period", int'(irq_pin), 0);
    pin(1'b0);
    chk("R5 irq on fall period", int'(irq_pin), 1);
    rd(2'd1, v); chk("R6 capture", v, 90);
    tick(5); pin(1'b1); pin(1'b0);
    tick(2); pin(1'b1); pin(1'b0);
    rd(2'd1, v); chk("R7 held", v, 95);
    tick(4); pin(1'b1); pin(1'b0);
    rd(2'd1, v); chk("R7 released", v, 96);

    // R8 pulse-width mode, edge bit 0 ignored
    wr(2'd0, mw(0, 0, 3)); wr(2'd1, 50); wr(2'd2, 3);
    tick(7); pin(1'b1);
    chk("R8 irq on rise", int'(irq_pin), 1);
    rd(2'd1, v); chk("R8 capture rise", v, 43);
    wr(2'd2, 3);
    tick(4); pin(1'b0);
    chk("R8 irq on fall", int'(irq_pin), 1);
    rd(2'd1, v); chk("R8 capture fall", v, 46);

    // R10 unused mode bits
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R10 mode readback", v, 16'h00F0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule